// File: doc/BRIEF.md
# Oldest-First Result Bus Arbiter

This block decides, every clock cycle, which finished instruction may drive the single shared result bus of an out-of-order core built around reservation stations. Each functional-unit source presents a request together with the producer tag, the result value, the instruction's sequence number and a two-bit kind code. The arbiter grants the bus to the eligible requester that is oldest in program order. The winning tag and value go out on a registered broadcast port one cycle later.

A source whose request loses keeps it asserted, with its tag, value and sequence number held, so a finished instruction waits between execute and write-back for as many cycles as the bus stays busy with older results. It drops the request at the clock edge where its grant is high. Requests from branches and stores are never eligible: branches resolve in execute and stores write memory without touching the result bus. This lets a source tie its request to "finished" without decoding the kind itself.

Age is compared with wrap-around sequence numbers. Sequence numbers in flight must span less than half the sequence space.

Top module: `cdb_age_arbiter`

## Requirements
- R1: While `rst` is high, `src_gnt` is all zero. In the cycle after a clock edge taken with `rst` high, `bc_valid` is 0.
- R2: `src_gnt` has at most one bit set in every cycle.
- R3: Sequence number a is older than b when (a - b) mod 2^SEQ_W is at least 2^(SEQ_W-1). The grant goes to an eligible source such that no other eligible source is older.
- R4: A source is eligible only when its `src_req` bit is 1 and its kind code is 2'b00 (arithmetic) or 2'b01 (load). Kind 2'b10 (branch) and kind 2'b11 (store) are never granted, whatever their age.
- R5: After a clock edge at which `src_gnt[i]` is 1, `bc_valid` is 1 and `bc_tag`/`bc_data` equal the tag and value that source i presented in that cycle.
- R6: After a clock edge at which no source is eligible, `bc_valid` is 0.
- R7: A source that loses keeps waiting. It is granted in a later cycle once every older eligible request has been granted and withdrawn.
- R8: When eligible sources carry equal sequence numbers, the lowest source index wins.
- R9: Whenever at least one source is eligible and `rst` is low, exactly one grant is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NUM_SRC | Per-source result request, held until granted |
| src_kind | input | 2*NUM_SRC | Per-source kind code: 00 arithmetic, 01 load, 10 branch, 11 store |
| src_tag | input | NUM_SRC*TAG_W | Per-source producer tag |
| src_data | input | NUM_SRC*DATA_W | Per-source result value |
| src_seq | input | NUM_SRC*SEQ_W | Per-source program-order sequence number |
| src_gnt | output | NUM_SRC | One-hot grant, same cycle as the winning request |
| bc_valid | output | 1 | Broadcast valid, registered |
| bc_tag | output | TAG_W | Broadcast producer tag, registered |
| bc_data | output | DATA_W | Broadcast result value, registered |

## Verification
The bench sweeps all 16 request masks against all 256 kind assignments of four sources. Each combination is tried with eight sequence layouts: spread layouts with spacing 1 and spacing 9, layouts that cross the wrap point, and one layout where every sequence number is equal. The spread layouts check that the age order is followed through the wrap (R3). The kind assignments show that branches and stores are filtered out even when they are the oldest (R4). The equal layout separates the index tie-break (R8) from the age rule. The masks with no eligible source tell an idle bus (R6) from a broadcast. A directed sequence then holds a younger request while an older one is served, to show that waiting results are not lost (R7).

// File: rtl/cdb_arb_pkg.sv
`timescale 1ns/1ps
package cdb_arb_pkg;

  typedef enum logic [1:0] {
    KIND_ALU    = 2'b00,
    KIND_LOAD   = 2'b01,
    KIND_BRANCH = 2'b10,
    KIND_STORE  = 2'b11
  } res_kind_e;

  // a is older than b when the modular difference lands in the upper half
  function automatic logic seq_older(input logic [31:0] a, input logic [31:0] b,
                                     input int unsigned w);
    logic [31:0] d;
    d = a - b;
    return d[w-1];
  endfunction

endpackage

// File: rtl/cdb_req_filter.sv
`timescale 1ns/1ps
module cdb_req_filter
  import cdb_arb_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input  logic [NUM_SRC-1:0]   req,
  input  logic [2*NUM_SRC-1:0] kind,
  output logic [NUM_SRC-1:0]   elig
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [1:0] k;
    assign k       = kind[2*i +: 2];
    assign elig[i] = req[i] && ((k == KIND_ALU) || (k == KIND_LOAD));
  end

endmodule

// File: rtl/cdb_age_tree.sv
`timescale 1ns/1ps
module cdb_age_tree
  import cdb_arb_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int SEQ_W   = 6
) (
  input  logic [NUM_SRC-1:0]       elig,
  input  logic [NUM_SRC*SEQ_W-1:0] seq,
  output logic                     win_valid,
  output logic [((NUM_SRC > 1) ? $clog2(NUM_SRC) : 1)-1:0] win_idx
);

  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int LEVELS = $clog2(NUM_SRC);
  localparam int LEAVES = 1 << LEVELS;
  localparam int NODES  = 2 * LEAVES - 1;

  // heap layout: node k has children 2k+1 and 2k+2, root is node 0
  logic [NODES-1:0] node_v;
  logic [SEQ_W-1:0] node_seq [NODES];
  logic [IDX_W-1:0] node_idx [NODES];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < NUM_SRC) begin : g_real
      assign node_v[LEAVES-1+i]   = elig[i];
      assign node_seq[LEAVES-1+i] = seq[i*SEQ_W +: SEQ_W];
      assign node_idx[LEAVES-1+i] = IDX_W'(i);
    end else begin : g_pad
      assign node_v[LEAVES-1+i]   = 1'b0;
      assign node_seq[LEAVES-1+i] = '0;
      assign node_idx[LEAVES-1+i] = '0;
    end
  end

  for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
    logic take_r;
    // left child keeps ties, so the lower index wins equal ages
    assign take_r = node_v[2*k+2] &&
                    (!node_v[2*k+1] ||
                     seq_older(32'(node_seq[2*k+2]), 32'(node_seq[2*k+1]), SEQ_W));
    assign node_v[k]   = node_v[2*k+1] | node_v[2*k+2];
    assign node_seq[k] = take_r ? node_seq[2*k+2] : node_seq[2*k+1];
    assign node_idx[k] = take_r ? node_idx[2*k+2] : node_idx[2*k+1];
  end

  assign win_valid = node_v[0];
  assign win_idx   = node_idx[0];

endmodule

// File: rtl/cdb_bcast_reg.sv
`timescale 1ns/1ps
module cdb_bcast_reg #(
  parameter int NUM_SRC = 4,
  parameter int TAG_W   = 5,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      fire,
  input  logic [IDX_W-1:0]          sel,
  input  logic [NUM_SRC*TAG_W-1:0]  tags,
  input  logic [NUM_SRC*DATA_W-1:0] datas,
  output logic                      bc_valid,
  output logic [TAG_W-1:0]          bc_tag,
  output logic [DATA_W-1:0]         bc_data
);

  logic [TAG_W-1:0]  mux_tag;
  logic [DATA_W-1:0] mux_data;

  always_comb begin
    mux_tag  = '0;
    mux_data = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel == IDX_W'(i)) begin
        mux_tag  = tags[i*TAG_W +: TAG_W];
        mux_data = datas[i*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bc_valid <= 1'b0;
    else     bc_valid <= fire;
  end

  // payload needs no reset: it is qualified by bc_valid
  always_ff @(posedge clk) begin
    if (fire) begin
      bc_tag  <= mux_tag;
      bc_data <= mux_data;
    end
  end

endmodule

// File: rtl/cdb_age_arbiter.sv
`timescale 1ns/1ps
module cdb_age_arbiter
  import cdb_arb_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int TAG_W   = 5,
  parameter int DATA_W  = 32,
  parameter int SEQ_W   = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SRC-1:0]        src_req,
  input  logic [2*NUM_SRC-1:0]      src_kind,
  input  logic [NUM_SRC*TAG_W-1:0]  src_tag,
  input  logic [NUM_SRC*DATA_W-1:0] src_data,
  input  logic [NUM_SRC*SEQ_W-1:0]  src_seq,
  output logic [NUM_SRC-1:0]        src_gnt,
  output logic                      bc_valid,
  output logic [TAG_W-1:0]          bc_tag,
  output logic [DATA_W-1:0]         bc_data
);

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam logic [NUM_SRC-1:0] GNT_ONE = NUM_SRC'(1);

  logic [NUM_SRC-1:0] elig;
  logic               win_valid;
  logic [IDX_W-1:0]   win_idx;
  logic               fire;

  cdb_req_filter #(.NUM_SRC(NUM_SRC)) u_filter (
    .req  (src_req),
    .kind (src_kind),
    .elig (elig)
  );

  cdb_age_tree #(.NUM_SRC(NUM_SRC), .SEQ_W(SEQ_W)) u_tree (
    .elig      (elig),
    .seq       (src_seq),
    .win_valid (win_valid),
    .win_idx   (win_idx)
  );

  assign fire    = win_valid && !rst;
  assign src_gnt = fire ? (GNT_ONE << win_idx) : '0;

  cdb_bcast_reg #(.NUM_SRC(NUM_SRC), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_bcast (
    .clk      (clk),
    .rst      (rst),
    .fire     (fire),
    .sel      (win_idx),
    .tags     (src_tag),
    .datas    (src_data),
    .bc_valid (bc_valid),
    .bc_tag   (bc_tag),
    .bc_data  (bc_data)
  );

  // ---------------- assertions ----------------
  p_gnt_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_gnt));

  p_work_conserving_r9: assert property (@(posedge clk) disable iff (rst)
    (|elig) |-> (|src_gnt));

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !(|elig) |=> !bc_valid);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    p_kind_filter_r4: assert property (@(posedge clk) disable iff (rst)
      src_gnt[i] |-> (src_req[i] && !src_kind[2*i+1]));

    p_bcast_payload_r5: assert property (@(posedge clk) disable iff (rst)
      src_gnt[i] |=> (bc_valid &&
                      bc_tag  == $past(src_tag[i*TAG_W +: TAG_W]) &&
                      bc_data == $past(src_data[i*DATA_W +: DATA_W])));

    for (genvar j = 0; j < NUM_SRC; j++) begin : g_pair
      if (j != i) begin : g_ne
        p_oldest_wins_r3: assert property (@(posedge clk) disable iff (rst)
          (src_gnt[i] && elig[j]) |->
            !seq_older(32'(src_seq[j*SEQ_W +: SEQ_W]), 32'(src_seq[i*SEQ_W +: SEQ_W]), SEQ_W));
      end
      if (j < i) begin : g_lo
        p_tie_low_index_r8: assert property (@(posedge clk) disable iff (rst)
          (src_gnt[i] && elig[j]) |->
            (src_seq[j*SEQ_W +: SEQ_W] != src_seq[i*SEQ_W +: SEQ_W]));
      end
    end
  end

endmodule

// File: tb/test_cdb_age_arbiter.sv
`timescale 1ns/1ps
module test_cdb_age_arbiter;

  localparam int N  = 4;
  localparam int TW = 5;
  localparam int DW = 32;
  localparam int SW = 6;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    src_req = '0;
  logic [2*N-1:0]  src_kind = '0;
  logic [N*TW-1:0] src_tag = '0;
  logic [N*DW-1:0] src_data = '0;
  logic [N*SW-1:0] src_seq = '0;
  logic [N-1:0]    src_gnt;
  logic            bc_valid;
  logic [TW-1:0]   bc_tag;
  logic [DW-1:0]   bc_data;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  cdb_age_arbiter #(.NUM_SRC(N), .TAG_W(TW), .DATA_W(DW), .SEQ_W(SW)) i_cdb_age_arbiter (
    .clk(clk), .rst(rst), .src_req(src_req), .src_kind(src_kind), .src_tag(src_tag),
    .src_data(src_data), .src_seq(src_seq), .src_gnt(src_gnt),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data)
  );

  task automatic chk(input bit ok, input string req, input longint got, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic bit older(input int a, input int b);
    return ((a - b) & 63) >= 32;
  endfunction

  // expected broadcast of the previous cycle
  bit            pv_valid = 0;
  logic [TW-1:0] pv_tag = '0;
  logic [DW-1:0] pv_data = '0;

  task automatic check_bc();
    chk(bc_valid == pv_valid, pv_valid ? "R5 valid" : "R6 idle", bc_valid, pv_valid);
    if (pv_valid) begin
      chk(bc_tag == pv_tag, "R5 tag", bc_tag, pv_tag);
      chk(bc_data == pv_data, "R5 data", bc_data, pv_data);
    end
  endtask

  // compute expected grant from the driven inputs, compare, remember broadcast
  task automatic check_gnt(input string lbl);
    int best;
    bit tie;
    logic [N-1:0] exp;
    best = -1;
    tie = 0;
    for (int i = 0; i < N; i++) begin
      if (src_req[i] && !src_kind[2*i+1]) begin
        if (best < 0) best = i;
        else if (older(int'(src_seq[i*SW +: SW]), int'(src_seq[best*SW +: SW]))) best = i;
        else if (src_seq[i*SW +: SW] == src_seq[best*SW +: SW]) tie = 1;
      end
    end
    exp = (best < 0) ? '0 : N'(1) << best;
    if (lbl.len() == 0) lbl = (best < 0) ? "R6/R4 none" : (tie ? "R8 tie" : "R3 age");
    chk(src_gnt == exp, lbl, src_gnt, exp);
    pv_valid = (best >= 0);
    if (best >= 0) begin
      pv_tag  = src_tag[best*TW +: TW];
      pv_data = src_data[best*DW +: DW];
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got 0 expected 1 (run ended)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int pat;
    // R1: reset with live requests
    src_req  = 4'b1111;
    src_seq  = {6'd4, 6'd3, 6'd2, 6'd1};
    repeat (2) @(negedge clk);
    chk(src_gnt == '0, "R1 gnt in reset", src_gnt, 0);
    chk(bc_valid == 1'b0, "R1 bc_valid in reset", bc_valid, 0);
    src_req = '0;
    rst = 1'b0;
    #1;
    check_gnt("R1 first cycle");

    // exhaustive sweep: request masks x kinds x sequence layouts
    pat = 0;
    for (int r = 0; r < 16; r++) begin
      for (int kc = 0; kc < 256; kc++) begin
        for (int s = 0; s < 8; s++) begin
          int base, step;
          @(negedge clk);
          check_bc();
          base = (s * 23 + 50) & 63;
          step = (s == 7) ? 0 : ((s < 4) ? 1 : 9);
          src_req  = N'(r);
          src_kind = 8'(kc);
          for (int i = 0; i < N; i++) begin
            src_seq[i*SW +: SW]  = SW'((base + ((i * 3 + s) % 4) * step) & 63);
            src_tag[i*TW +: TW]  = TW'(i * 4 + (r & 3));
            src_data[i*DW +: DW] = DW'((pat << 2) | i);
          end
          pat++;
          #1;
          check_gnt("");
        end
      end
    end

    // R7: younger result waits while the older one is served
    @(negedge clk);
    check_bc();
    src_kind = '0;
    src_req  = 4'b0101;
    src_seq  = {6'd0, 6'd8, 6'd0, 6'd10};
    src_tag  = {5'd0, 5'd22, 5'd0, 5'd20};
    #1;
    chk(src_gnt == 4'b0100, "R7 older first", src_gnt, 4'b0100);
    check_gnt("R7 older first");
    @(negedge clk);
    check_bc();
    chk(src_gnt == 4'b0100, "R7 hold until edge", src_gnt, 4'b0100);
    src_req = 4'b0001;
    #1;
    chk(src_gnt == 4'b0001, "R7 waiting served", src_gnt, 4'b0001);
    check_gnt("R7 waiting served");
    @(negedge clk);
    check_bc();
    chk(bc_tag == 5'd20, "R7 broadcast tag", bc_tag, 20);
    src_req = '0;
    #1;
    check_gnt("R6 idle after");
    @(negedge clk);
    check_bc();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule